// File: doc/BRIEF.md
# Turbo Rate Matching Unit

This block sits after a rate 1/3 turbo encoder. It takes the systematic stream and the two parity streams, one bit of each per accepted beat, and stores each stream through its own sub-block interleaver. The interleaver is a 32-column matrix. Dummy positions fill the front of the matrix, and the columns are read out in bit-reversed order. The third stream sees the same matrix with its index moved on by one.

The three interleaved streams together form a virtual circular buffer. Every interleaved systematic bit comes first. After them, the first and second parity streams alternate one bit at a time. A read walk starts at a position chosen by a two-bit redundancy version. It wraps at the end of the buffer, skips every dummy position, and emits exactly the requested number of real bits, one per output beat. A new job is accepted only while the unit is idle.

Top module: `turbo_rate_match`

## Requirements
- R1: After reset, `busy` and `out_valid` are low.
- R2: A `cfg_start` pulse while idle latches D = `cfg_len` (1 to D_MAX), E = `cfg_e` and `cfg_rv`. The unit then accepts exactly D triples, one on each cycle with `in_valid` high, and cycles with `in_valid` low add no bit. The matrix has R = ceil(D/32) rows and Kp = 32*R positions, and its first Kp-D positions are dummies.
- R3: For the systematic and first parity streams, input bit i sits at matrix index k = Kp-D+i (row k/32, column k mod 32). Interleaved position j reads row j mod R of column P(j/R), where P(p) is the 5-bit reversal of p.
- R4: Interleaved position j of the second parity stream holds matrix index (P(j/R) + 32*(j mod R) + 1) mod Kp.
- R5: Buffer position j < Kp holds systematic position j. Buffer position Kp+2j holds first-parity position j, and buffer position Kp+2j+1 holds second-parity position j.
- R6: Reading starts at buffer position R*(24*rv+2).
- R7: Positions holding a dummy are skipped and produce no output beat.
- R8: The read wraps modulo 3*Kp and stops after exactly E emitted bits. `out_last` is high on the E-th bit only. With E = 0 no bit is emitted and the unit returns to idle.
- R9: A `cfg_start` while `busy` is high is ignored and does not alter the running job.
- R10: `out_valid` stays low while triples are being loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start | input | 1 | Start a job (honoured only when idle) |
| cfg_len | input | LEN_W | Stream length D |
| cfg_e | input | E_W | Number of output bits E |
| cfg_rv | input | 2 | Redundancy version |
| in_valid | input | 1 | Input triple present |
| in_sys | input | 1 | Systematic bit |
| in_par1 | input | 1 | First parity bit |
| in_par2 | input | 1 | Second parity bit |
| busy | output | 1 | Job in progress |
| out_valid | output | 1 | Output bit present |
| out_bit | output | 1 | Selected bit |
| out_last | output | 1 | Final bit of the job |

## Verification
The bench aims at four hard cases:
- Full matrices with no dummy at all, where the second parity index wraps from position zero to Kp-1. A wrong modulo there scrambles the third stream.
- A single-bit stream, where 31 of every 32 positions are dummies and the read must circle the buffer many times. A design that emits dummies, or stops at the buffer end, gives the wrong bit count.
- Every redundancy version, including the two that start inside the parity region on a first-parity bit. An off-by-one start shifts the whole output.
- E = 0, gapped input beats, and a stray start request during loading. A design that miscounts beats, or reloads its configuration mid-job, emits bits that do not match.

// File: rtl/rm_pkg.sv
package rm_pkg;

   typedef enum logic [1:0] {
      RM_IDLE = 2'd0,
      RM_LOAD = 2'd1,
      RM_READ = 2'd2
   } rm_phase_e;

   // Inter-column permutation: read position p takes column bitrev5(p);
   // the mapping is its own inverse.
   function automatic logic [4:0] col_perm(input logic [4:0] c);
      return {c[0], c[1], c[2], c[3], c[4]};
   endfunction

endpackage

// File: rtl/rm_bitbank.sv
module rm_bitbank #(
   parameter int DEPTH = 128,
   parameter int AW    = 7
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic          wr_bit,
   input  logic [AW-1:0] rd_addr,
   output logic          rd_bit
);
   logic mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_bit;
      rd_bit <= mem[rd_addr];
   end
endmodule

// File: rtl/rm_wr_map.sv
module rm_wr_map #(
   parameter int AW    = 7,
   parameter int K_W   = 8,
   parameter int ROW_W = 3
) (
   input  logic [K_W-1:0]   nat_k,
   input  logic [ROW_W-1:0] rows,
   input  logic [K_W-1:0]   kpi,
   output logic [AW-1:0]    addr_main,
   output logic [AW-1:0]    addr_shift
);
   import rm_pkg::*;

   logic [K_W-1:0] k_prev;

   always_comb begin
      // matrix index seen by the offset interleaver is one lower, modulo kpi
      k_prev     = (nat_k == '0) ? kpi - K_W'(1) : nat_k - K_W'(1);
      addr_main  = AW'(K_W'(col_perm(nat_k[4:0])) * K_W'(rows) + (nat_k >> 5));
      addr_shift = AW'(K_W'(col_perm(k_prev[4:0])) * K_W'(rows) + (k_prev >> 5));
   end
endmodule

// File: rtl/rm_rd_walk.sv
module rm_rd_walk #(
   parameter int AW    = 7,
   parameter int K_W   = 8,
   parameter int ROW_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init,
   input  logic [1:0]       rv,
   input  logic             step,
   input  logic [ROW_W-1:0] rows,
   input  logic [4:0]       nd,
   input  logic [K_W-1:0]   kpi,
   output logic [AW-1:0]    addr,
   output logic [1:0]       bank_sel,
   output logic             is_null
);
   import rm_pkg::*;

   logic [4:0]       col_q;
   logic [ROW_W-1:0] row_q;
   logic             par_q;
   logic             odd_q;
   logic [ROW_W-1:0] last_row;
   logic [4:0]       start_col;
   logic [K_W-1:0]   base;
   logic [K_W-1:0]   nat;

   always_comb begin
      case (rv)
         2'd0:    start_col = 5'd2;
         2'd1:    start_col = 5'd26;
         2'd2:    start_col = 5'd9;
         default: start_col = 5'd21;
      endcase
   end

   assign last_row = rows - ROW_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q <= '0;
         row_q <= '0;
         par_q <= 1'b0;
         odd_q <= 1'b0;
      end else if (init) begin
         col_q <= start_col;
         row_q <= '0;
         par_q <= rv[1];
         odd_q <= 1'b0;
      end else if (step) begin
         if (par_q && !odd_q) begin
            odd_q <= 1'b1;
         end else begin
            odd_q <= 1'b0;
            if (row_q == last_row) begin
               row_q <= '0;
               if (col_q == 5'd31) begin
                  col_q <= '0;
                  par_q <= ~par_q;
               end else begin
                  col_q <= col_q + 5'd1;
               end
            end else begin
               row_q <= row_q + ROW_W'(1);
            end
         end
      end
   end

   always_comb begin
      base     = K_W'({row_q, col_perm(col_q)});
      if (par_q && odd_q)
         nat = (base + K_W'(1) == kpi) ? '0 : base + K_W'(1);
      else
         nat = base;
      is_null  = nat < K_W'(nd);
      addr     = AW'(K_W'(col_q) * K_W'(rows) + K_W'(row_q));
      bank_sel = par_q ? (odd_q ? 2'd2 : 2'd1) : 2'd0;
   end

   assert_row_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (row_q < rows));
endmodule

// File: rtl/turbo_rate_match.sv
module turbo_rate_match #(
   parameter int D_MAX = 128,
   parameter int E_W   = 12,
   parameter int LEN_W = $clog2(D_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_start,
   input  logic [LEN_W-1:0] cfg_len,
   input  logic [E_W-1:0]   cfg_e,
   input  logic [1:0]       cfg_rv,
   input  logic             in_valid,
   input  logic             in_sys,
   input  logic             in_par1,
   input  logic             in_par2,
   output logic             busy,
   output logic             out_valid,
   output logic             out_bit,
   output logic             out_last
);
   import rm_pkg::*;

   localparam int R_MAX   = (D_MAX + 31) / 32;
   localparam int KPI_MAX = 32 * R_MAX;
   localparam int AW      = $clog2(KPI_MAX);
   localparam int K_W     = $clog2(KPI_MAX + 1);
   localparam int ROW_W   = $clog2(R_MAX + 1);
   localparam int PAD_W   = LEN_W + 6;

   if (D_MAX < 1) begin : g_bad_dmax
      $error("D_MAX must be at least 1");
   end
   if (E_W < 1) begin : g_bad_ew
      $error("E_W must be at least 1");
   end
   if (LEN_W < $clog2(D_MAX + 1)) begin : g_bad_lenw
      $error("LEN_W too narrow for D_MAX");
   end

   rm_phase_e        phase_q;
   logic [LEN_W-1:0] len_q;
   logic [E_W-1:0]   e_q;
   logic [1:0]       rv_q;
   logic [ROW_W-1:0] rows_q;
   logic [4:0]       nd_q;
   logic [K_W-1:0]   kpi_q;
   logic [K_W-1:0]   wr_k;
   logic [LEN_W-1:0] wr_cnt;
   logic [E_W-1:0]   emit_cnt;
   logic [1:0]       sel1_q;

   logic [ROW_W-1:0] rows_n;
   logic [K_W-1:0]   kpi_n;
   logic             take_cfg;
   logic             load_fire;
   logic             load_done;
   logic             issue;
   logic             emit;
   logic [AW-1:0]    wr_addr_a;
   logic [AW-1:0]    wr_addr_b;
   logic [AW-1:0]    rd_addr;
   logic [1:0]       bank_sel;
   logic             rd_null;
   logic [2:0]       in_bits;
   logic [2:0]       rd_bits;

   assign rows_n    = ROW_W'((PAD_W'(cfg_len) + PAD_W'(31)) >> 5);
   assign kpi_n     = K_W'(rows_n) << 5;
   assign take_cfg  = cfg_start && (phase_q == RM_IDLE);
   assign load_fire = in_valid && (phase_q == RM_LOAD);
   assign load_done = load_fire && (wr_cnt == len_q - LEN_W'(1));
   assign issue     = (phase_q == RM_READ) && (emit_cnt != e_q);
   assign emit      = issue && !rd_null;
   assign in_bits   = {in_par2, in_par1, in_sys};
   assign busy      = (phase_q != RM_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= RM_IDLE;
         len_q    <= '0;
         e_q      <= '0;
         rv_q     <= '0;
         rows_q   <= '0;
         nd_q     <= '0;
         kpi_q    <= '0;
         wr_k     <= '0;
         wr_cnt   <= '0;
         emit_cnt <= '0;
      end else begin
         case (phase_q)
            RM_IDLE: if (take_cfg) begin
               len_q    <= cfg_len;
               e_q      <= cfg_e;
               rv_q     <= cfg_rv;
               rows_q   <= rows_n;
               kpi_q    <= kpi_n;
               nd_q     <= 5'(kpi_n - K_W'(cfg_len));
               wr_k     <= K_W'(5'(kpi_n - K_W'(cfg_len)));
               wr_cnt   <= '0;
               emit_cnt <= '0;
               phase_q  <= RM_LOAD;
            end
            RM_LOAD: if (load_fire) begin
               wr_k   <= wr_k + K_W'(1);
               wr_cnt <= wr_cnt + LEN_W'(1);
               if (load_done) phase_q <= RM_READ;
            end
            RM_READ: begin
               if (emit) emit_cnt <= emit_cnt + E_W'(1);
               if (emit_cnt == e_q) phase_q <= RM_IDLE;
            end
            default: phase_q <= RM_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_last  <= 1'b0;
         sel1_q    <= '0;
      end else begin
         out_valid <= emit;
         out_last  <= emit && (emit_cnt == e_q - E_W'(1));
         sel1_q    <= bank_sel;
      end
   end

   always_comb begin
      case (sel1_q)
         2'd0:    out_bit = rd_bits[0];
         2'd1:    out_bit = rd_bits[1];
         default: out_bit = rd_bits[2];
      endcase
   end

   rm_wr_map #(.AW(AW), .K_W(K_W), .ROW_W(ROW_W)) u_wr_map (
      .nat_k      (wr_k),
      .rows       (rows_q),
      .kpi        (kpi_q),
      .addr_main  (wr_addr_a),
      .addr_shift (wr_addr_b)
   );

   rm_rd_walk #(.AW(AW), .K_W(K_W), .ROW_W(ROW_W)) u_rd_walk (
      .clk      (clk),
      .rst_n    (rst_n),
      .init     (load_done),
      .rv       (rv_q),
      .step     (issue),
      .rows     (rows_q),
      .nd       (nd_q),
      .kpi      (kpi_q),
      .addr     (rd_addr),
      .bank_sel (bank_sel),
      .is_null  (rd_null)
   );

   for (genvar g = 0; g < 3; g++) begin : g_bank
      rm_bitbank #(.DEPTH(KPI_MAX), .AW(AW)) u_bank (
         .clk     (clk),
         .wr_en   (load_fire),
         .wr_addr ((g == 2) ? wr_addr_b : wr_addr_a),
         .wr_bit  (in_bits[g]),
         .rd_addr (rd_addr),
         .rd_bit  (rd_bits[g])
      );
   end

   assert_cfg_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      take_cfg |-> (cfg_len != '0) && (cfg_len <= LEN_W'(D_MAX)));
   assert_wr_in_matrix_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load_fire |-> (K_W'(wr_addr_a) < kpi_q) && (K_W'(wr_addr_b) < kpi_q));
   assert_last_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);
   assert_nothing_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |=> !out_valid);
   assert_emit_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == RM_READ) |-> (emit_cnt <= e_q));
   assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(len_q) && $stable(e_q) && $stable(rv_q)));
   assert_quiet_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != RM_READ) |=> !out_valid);
endmodule

// File: tb/turbo_rate_match_tb.sv
`timescale 1ns/1ps
module turbo_rate_match_tb_top;
   localparam int DMAX = 128;
   localparam int EW   = 12;
   localparam int LW   = $clog2(DMAX + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_start = 1'b0;
   logic [LW-1:0] cfg_len = '0;
   logic [EW-1:0] cfg_e = '0;
   logic [1:0] cfg_rv = '0;
   logic in_valid = 1'b0, in_sys = 1'b0, in_par1 = 1'b0, in_par2 = 1'b0;
   logic busy, out_valid, out_bit, out_last;

   always #2.5 clk = ~clk;

   turbo_rate_match #(.D_MAX(DMAX), .E_W(EW)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_len(cfg_len),
      .cfg_e(cfg_e), .cfg_rv(cfg_rv), .in_valid(in_valid), .in_sys(in_sys),
      .in_par1(in_par1), .in_par2(in_par2), .busy(busy), .out_valid(out_valid),
      .out_bit(out_bit), .out_last(out_last));

   int checks = 0;
   int failures = 0;
   bit finished = 0;
   bit exp_q[$];
   int got_cnt = 0;
   int last_cnt = 0;
   int bs[DMAX], bp1[DMAX], bp2[DMAX];
   int unsigned seed = 32'h1234_5678;
   int perm[32] = '{0,16,8,24,4,20,12,28,2,18,10,26,6,22,14,30,
                    1,17,9,25,5,21,13,29,3,19,11,27,7,23,15,31};

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int next_bit();
      seed = seed * 32'd1103515245 + 32'd12345;
      return int'(seed[16]);
   endfunction

   // Behavioural model: matrices with dummies (-1), column permutation,
   // buffer collection, start offset, wrap and pruning (R3 R4 R5 R6 R7 R8).
   task automatic build_expected(input int d, input int e, input int rv);
      int r, kp, nd, idx, n;
      int ys[], y1[], y2[], w[];
      r = (d + 31) / 32;
      kp = 32 * r;
      nd = kp - d;
      ys = new[kp]; y1 = new[kp]; y2 = new[kp]; w = new[3 * kp];
      for (int k = 0; k < kp; k++) begin
         ys[k] = (k < nd) ? -1 : bs[k - nd];
         y1[k] = (k < nd) ? -1 : bp1[k - nd];
         y2[k] = (k < nd) ? -1 : bp2[k - nd];
      end
      for (int j = 0; j < kp; j++) begin
         int m;
         m = perm[j / r] + 32 * (j % r);
         w[j] = ys[m];
         w[kp + 2 * j] = y1[m];
         w[kp + 2 * j + 1] = y2[(m + 1) % kp];
      end
      exp_q.delete();
      idx = r * (24 * rv + 2);
      n = 0;
      while (n < e) begin
         if (w[idx] != -1) begin
            exp_q.push_back(w[idx][0]);
            n++;
         end
         idx = (idx + 1) % (3 * kp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         got_cnt++;
         if (exp_q.size() == 0) begin
            check(1'b0, "R8 extra output bit", 1, 0);
         end else begin
            bit b;
            b = exp_q.pop_front();
            check(out_bit == b, "R3 R4 R5 R6 R7 bit mismatch", int'(out_bit), int'(b));
         end
         if (out_last) begin
            last_cnt++;
            check(exp_q.size() == 0, "R8 out_last before final bit", exp_q.size(), 0);
         end
      end
   end

   task automatic run_job(input int d, input int e, input int rv,
                          input bit gaps, input bit stray);
      for (int i = 0; i < d; i++) begin
         bs[i] = next_bit(); bp1[i] = next_bit(); bp2[i] = next_bit();
      end
      build_expected(d, e, rv);
      got_cnt = 0;
      last_cnt = 0;
      @(posedge clk); #1;
      cfg_start = 1'b1; cfg_len = LW'(d); cfg_e = EW'(e); cfg_rv = 2'(rv);
      @(posedge clk); #1;
      cfg_start = 1'b0;
      for (int i = 0; i < d; i++) begin
         if (gaps && (i % 3 == 1)) begin
            in_valid = 1'b0;
            in_sys = ~in_sys;
            if (stray && i == 4) begin
               cfg_start = 1'b1; cfg_len = LW'(7); cfg_e = EW'(3); cfg_rv = ~2'(rv);
            end
            @(negedge clk);
            check(out_valid == 1'b0, "R10 output during load", int'(out_valid), 0);
            @(posedge clk); #1;
            cfg_start = 1'b0;
         end
         in_valid = 1'b1; in_sys = bs[i][0]; in_par1 = bp1[i][0]; in_par2 = bp2[i][0];
         @(negedge clk);
         check(busy == 1'b1, "R2 busy during load", int'(busy), 1);
         check(out_valid == 1'b0, "R10 output during load", int'(out_valid), 0);
         @(posedge clk); #1;
      end
      in_valid = 1'b0;
      @(negedge clk);
      while (busy) @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      check(got_cnt == e, "R8 emitted bit count", got_cnt, e);
      check(last_cnt == ((e > 0) ? 1 : 0), "R8 out_last count", last_cnt, (e > 0) ? 1 : 0);
      check(exp_q.size() == 0, "R8 missing bits", exp_q.size(), 0);
      check(busy == 1'b0, "R2 idle after job", int'(busy), 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
      check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(busy == 1'b0, "R1 busy after release", int'(busy), 0);
      // R3 R4: full matrix, no dummies, offset interleaver wraps index 0
      run_job(128, 400, 0, 1'b0, 1'b0);
      // stray beats while idle must not enter the next job (R2)
      @(posedge clk); #1 in_valid = 1'b1; in_sys = 1'b1;
      @(posedge clk); #1 in_valid = 1'b0;
      // R6 R7: partial matrix, rv1
      run_job(100, 300, 1, 1'b0, 1'b0);
      // R7 R8: single bit streams, heavy pruning and many wraps, rv2
      run_job(1, 10, 2, 1'b0, 1'b0);
      // R2 R9: gapped beats with a stray start request, rv3
      run_job(40, 150, 3, 1'b1, 1'b1);
      // R8: zero-length output
      run_job(70, 0, 0, 1'b0, 1'b0);
      // R8: request beyond buffer length, rv2 start in parity region
      run_job(33, 500, 2, 1'b1, 1'b0);
      // R6: rv3 on full matrix
      run_job(96, 200, 3, 1'b0, 1'b0);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL R8 watchdog expired actual=%0d expected=%0d", got_cnt, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule